// File: doc/BRIEF.md
# DMA Address High-Bit and VMID Override

This block sits in the address path of a DMA engine that serves several queues. Each request carries a 64-bit buffer address, a queue number and a traffic kind (data, prefetch or completion). For data traffic the block can overwrite a programmable number of the most significant address bits with bits from a per-queue 32-bit replacement register. It also attaches a 16-bit virtual-machine identifier (VMID) to every request. The result leaves one clock after the request enters, together with a delayed valid.

For data requests the VMID is merged bit by bit from two sources, the top 16 address bits and a register value, under a per-queue mask. Prefetch and completion requests take a fixed VMID from their own registers when their enable is set. When the override for a request's kind is off, the address passes through unchanged. The VMID then comes from a per-queue fallback: the queue register, the address tag bits [63:48], or zero.

Configuration is written through a simple write port: a queue number, a register select and 32 bits of data. A write takes effect for requests presented from the cycle after the write edge.

Top module: `addr_ovr_top`

## Requirements
- R1: After reset, out_valid, out_addr and out_vmid are zero and every queue's configuration is cleared, so every request passes through with VMID zero.
- R2: out_valid equals in_valid of the previous cycle, and out_addr/out_vmid reflect the request of that cycle. When in_valid is low, out_addr and out_vmid hold their values.
- R3: A data request whose queue has the data override enabled and a count of 0 leaves the address unchanged.
- R4: For a count N from 1 to 32, a data request with the override enabled gets address bits [63:64-N] from replacement bits [31:32-N]. All other address bits, including all of [31:0], are unchanged. Example: N=8 puts replacement [31:24] on [63:56].
- R5: Count values from 33 to 63 act as 32.
- R6: For a data request with the override enabled, VMID bit i is address bit 48+i when mask bit i is 1, and data VMID register bit i when mask bit i is 0.
- R7: A prefetch request (kind 1) never has its address changed. With the prefetch enable set, its VMID is the prefetch VMID register.
- R8: A completion request (kind 2) never has its address changed. With the completion enable set, its VMID is the completion VMID register.
- R9: When the enable for a request's kind is clear, the VMID falls back as follows. It is the queue VMID if the queue-VMID enable is set. Otherwise it is address bits [63:48] if the descriptor-tag enable is set. Otherwise it is zero. The queue VMID wins when both enables are set.
- R10: A configuration write changes only the queue named by cfg_queue.
- R11: Register select map. Select 0 is control: bit0 data enable, bit1 prefetch enable, bit2 completion enable, bit3 queue-VMID enable, bit4 descriptor-tag enable, bits[13:8] count. Select 1 is the 32-bit replacement. Select 2 holds the data VMID in [15:0] and the mask in [31:16]. Select 3 holds the prefetch VMID in [15:0] and the completion VMID in [31:16]. Select 4 holds the queue VMID in [15:0]. Selects 5 to 7 are ignored.
- R12: Kind 3 is never overridden: the address passes unchanged and the VMID follows the R9 fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_queue | input | 2 | Queue addressed by the write |
| cfg_sel | input | 3 | Register select (R11) |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Request valid |
| in_queue | input | 2 | Queue of the request |
| in_kind | input | 2 | 0 data, 1 prefetch, 2 completion, 3 reserved |
| in_addr | input | 64 | Buffer address |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_addr | output | 64 | Rewritten address |
| out_vmid | output | 16 | Attached VMID |

## Verification
The hardest cases to reach from the ports are at the edges of the replacement count: 0, 1, 31 and 32, and the clamped values 40 and 63. A wrong boundary in the bit-selection mask shows up only at these counts. The stimulus writes each count through the control register and sends a data request after each write. The address uses distinct nibbles, so a single misplaced bit changes the compared value. The VMID fallback order is driven the same way: the two fallback enables are switched on one at a time and then together, with a prefetch override disabled. Writes to one queue are followed by requests on another queue to show that the other queue is untouched.

// File: rtl/addr_ovr_pkg.sv
`timescale 1ns/1ps
package addr_ovr_pkg;
    localparam int ADDR_W = 64;
    localparam int HI_W   = 32;
    localparam int LO_W   = ADDR_W - HI_W;
    localparam int VMID_W = 16;
    localparam int CNT_W  = 6;
    localparam int CFG_W  = 32;
    localparam int SEL_W  = 3;
    localparam int UP_LSB = CFG_W / 2;
    localparam int CNT_LSB = 8;

    typedef enum logic [1:0] {
        KIND_DATA  = 2'd0,
        KIND_PREF  = 2'd1,
        KIND_COMPL = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL       = 3'd0,
        SEL_REPL       = 3'd1,
        SEL_DATA_VMID  = 3'd2,
        SEL_SIDE_VMID  = 3'd3,
        SEL_QUEUE_VMID = 3'd4
    } sel_e;

    typedef struct packed {
        logic              data_en;
        logic              pref_en;
        logic              compl_en;
        logic              qvmid_en;
        logic              tag_en;
        logic [CNT_W-1:0]  cnt;
        logic [HI_W-1:0]   repl;
        logic [VMID_W-1:0] dvmid;
        logic [VMID_W-1:0] dmask;
        logic [VMID_W-1:0] pvmid;
        logic [VMID_W-1:0] cvmid;
        logic [VMID_W-1:0] qvmid;
    } qcfg_t;
endpackage

// File: rtl/addr_ovr_cfg_bank.sv
`timescale 1ns/1ps
module addr_ovr_cfg_bank
    import addr_ovr_pkg::*;
#(
    parameter int NUM_Q = 4,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [QW-1:0]    cfg_queue,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [QW-1:0]    rd_queue,
    output qcfg_t            rd_cfg
);
    qcfg_t regs [NUM_Q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NUM_Q; q++) regs[q] <= '0;
        end else if (cfg_we) begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (cfg_queue == QW'(q)) begin
                    case (cfg_sel)
                        SEL_CTRL: begin
                            regs[q].data_en  <= cfg_wdata[0];
                            regs[q].pref_en  <= cfg_wdata[1];
                            regs[q].compl_en <= cfg_wdata[2];
                            regs[q].qvmid_en <= cfg_wdata[3];
                            regs[q].tag_en   <= cfg_wdata[4];
                            regs[q].cnt      <= cfg_wdata[CNT_LSB +: CNT_W];
                        end
                        SEL_REPL: regs[q].repl <= cfg_wdata[HI_W-1:0];
                        SEL_DATA_VMID: begin
                            regs[q].dvmid <= cfg_wdata[VMID_W-1:0];
                            regs[q].dmask <= cfg_wdata[UP_LSB +: VMID_W];
                        end
                        SEL_SIDE_VMID: begin
                            regs[q].pvmid <= cfg_wdata[VMID_W-1:0];
                            regs[q].cvmid <= cfg_wdata[UP_LSB +: VMID_W];
                        end
                        SEL_QUEUE_VMID: regs[q].qvmid <= cfg_wdata[VMID_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    assign rd_cfg = regs[rd_queue];
endmodule

// File: rtl/addr_ovr_hi_merge.sv
`timescale 1ns/1ps
module addr_ovr_hi_merge
    import addr_ovr_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  logic [HI_W-1:0]  repl,
    input  logic [HI_W-1:0]  orig,
    output logic [HI_W-1:0]  merged
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(HI_W);

    logic [CNT_W-1:0] eff_cnt;
    logic [HI_W-1:0]  take;

    assign eff_cnt = (cnt > MAX_CNT) ? MAX_CNT : cnt;

    // bit b is among the top eff_cnt bits when b + eff_cnt reaches HI_W
    for (genvar b = 0; b < HI_W; b++) begin : g_bit
        assign take[b] = (int'(eff_cnt) + b) >= HI_W;
    end

    assign merged = (repl & take) | (orig & ~take);
endmodule

// File: rtl/addr_ovr_vmid_sel.sv
`timescale 1ns/1ps
module addr_ovr_vmid_sel
    import addr_ovr_pkg::*;
(
    input  logic [1:0]        kind,
    input  qcfg_t             cfg,
    input  logic [VMID_W-1:0] addr_tag,
    output logic [VMID_W-1:0] vmid,
    output logic              repl_en
);
    logic [VMID_W-1:0] fallback;

    always_comb begin
        if (cfg.qvmid_en)    fallback = cfg.qvmid;
        else if (cfg.tag_en) fallback = addr_tag;
        else                 fallback = '0;
    end

    always_comb begin
        repl_en = 1'b0;
        vmid    = fallback;
        unique case (kind_e'(kind))
            KIND_DATA: begin
                if (cfg.data_en) begin
                    repl_en = 1'b1;
                    vmid    = (cfg.dmask & addr_tag) | (~cfg.dmask & cfg.dvmid);
                end
            end
            KIND_PREF:  if (cfg.pref_en)  vmid = cfg.pvmid;
            KIND_COMPL: if (cfg.compl_en) vmid = cfg.cvmid;
            KIND_RSVD:  vmid = fallback;
        endcase
    end
endmodule

// File: rtl/addr_ovr_top.sv
`timescale 1ns/1ps
module addr_ovr_top
    import addr_ovr_pkg::*;
#(
    parameter int NUM_Q = 4,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QW-1:0]     cfg_queue,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [QW-1:0]     in_queue,
    input  logic [1:0]        in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [VMID_W-1:0] out_vmid
);
    qcfg_t             cur_cfg;
    logic [HI_W-1:0]   merged_hi;
    logic [VMID_W-1:0] nxt_vmid;
    logic              repl_en;
    logic [ADDR_W-1:0] nxt_addr;

    addr_ovr_cfg_bank #(.NUM_Q(NUM_Q)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_queue (cfg_queue),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rd_queue  (in_queue),
        .rd_cfg    (cur_cfg)
    );

    addr_ovr_hi_merge u_merge (
        .cnt    (cur_cfg.cnt),
        .repl   (cur_cfg.repl),
        .orig   (in_addr[ADDR_W-1:LO_W]),
        .merged (merged_hi)
    );

    addr_ovr_vmid_sel u_vmid (
        .kind     (in_kind),
        .cfg      (cur_cfg),
        .addr_tag (in_addr[ADDR_W-1 -: VMID_W]),
        .vmid     (nxt_vmid),
        .repl_en  (repl_en)
    );

    assign nxt_addr = repl_en ? {merged_hi, in_addr[LO_W-1:0]} : in_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_vmid  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= nxt_addr;
                out_vmid <= nxt_vmid;
            end
        end
    end
endmodule

// File: rtl/addr_ovr_chk.sv
`timescale 1ns/1ps
module addr_ovr_chk
    import addr_ovr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_kind,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [VMID_W-1:0] out_vmid
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_addr == '0 && out_vmid == '0));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_addr) && $stable(out_vmid)));

    p_low_half_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_addr[LO_W-1:0] == $past(in_addr[LO_W-1:0]));

    p_side_addr_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind != 2'd0) |=> out_addr == $past(in_addr));
endmodule

bind addr_ovr_top addr_ovr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_vmid  (out_vmid)
);

// File: tb/addr_ovr_top_tb_top.sv
`timescale 1ns/1ps
module addr_ovr_top_tb_top;
    localparam int NQ = 4;
    localparam int QW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [QW-1:0] cfg_queue = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [QW-1:0] in_queue = '0;
    logic [1:0]  in_kind = '0;
    logic [63:0] in_addr = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic [15:0] out_vmid;

    always #2.5 clk = ~clk;

    addr_ovr_top #(.NUM_Q(NQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_queue(cfg_queue),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
        .in_queue(in_queue), .in_kind(in_kind), .in_addr(in_addr),
        .out_valid(out_valid), .out_addr(out_addr), .out_vmid(out_vmid)
    );

    typedef struct {
        logic [63:0] a;
        logic [15:0] v;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int errors = 0;
    logic [63:0] last_addr = '0;
    logic [15:0] last_vmid = '0;

    // bench copy of the configuration, following the R11 map
    logic        m_den[NQ], m_pen[NQ], m_cen[NQ], m_qen[NQ], m_ten[NQ];
    logic [5:0]  m_cnt[NQ];
    logic [31:0] m_rep[NQ];
    logic [15:0] m_dv[NQ], m_dm[NQ], m_pv[NQ], m_cv[NQ], m_qv[NQ];

    task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_addr(int q, logic [1:0] k, logic [63:0] a);
        int n;
        logic [31:0] lowmask;
        n = (m_cnt[q] > 6'd32) ? 32 : int'(m_cnt[q]);
        lowmask = 32'(64'hFFFF_FFFF >> n);
        if (k == 2'd0 && m_den[q])
            return {(m_rep[q] & ~lowmask) | (a[63:32] & lowmask), a[31:0]};
        return a;
    endfunction

    function automatic logic [15:0] model_vmid(int q, logic [1:0] k, logic [63:0] a);
        logic [15:0] fb;
        fb = m_qen[q] ? m_qv[q] : (m_ten[q] ? a[63:48] : 16'h0);
        case (k)
            2'd0: return m_den[q] ? ((m_dm[q] & a[63:48]) | (~m_dm[q] & m_dv[q])) : fb;
            2'd1: return m_pen[q] ? m_pv[q] : fb;
            2'd2: return m_cen[q] ? m_cv[q] : fb;
            default: return fb;
        endcase
    endfunction

    function automatic logic [31:0] ctrl(bit d, bit p, bit c, bit qv, bit tg, int n);
        return (32'(n) << 8) | {27'd0, tg, qv, c, p, d};
    endfunction

    task automatic cfg_write(int q, int sel, logic [31:0] w);
        cfg_we = 1'b1; cfg_queue = QW'(q); cfg_sel = 3'(sel); cfg_wdata = w;
        case (sel)
            0: begin
                m_den[q] = w[0]; m_pen[q] = w[1]; m_cen[q] = w[2];
                m_qen[q] = w[3]; m_ten[q] = w[4]; m_cnt[q] = w[13:8];
            end
            1: m_rep[q] = w;
            2: begin m_dv[q] = w[15:0]; m_dm[q] = w[31:16]; end
            3: begin m_pv[q] = w[15:0]; m_cv[q] = w[31:16]; end
            4: m_qv[q] = w[15:0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_lit(int q, logic [1:0] k, logic [63:0] a,
                            logic [63:0] ea, logic [15:0] ev, string tag);
        exp_t e;
        e.a = ea; e.v = ev; e.tag = tag;
        sbq.push_back(e);
        last_addr = ea; last_vmid = ev;
        in_valid = 1'b1; in_queue = QW'(q); in_kind = k; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send(int q, logic [1:0] k, logic [63:0] a, string tag);
        send_lit(q, k, a, model_addr(q, k, a), model_vmid(q, k, a), tag);
    endtask

    // monitor: compare each result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected output: actual %h expected none", out_addr);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check64(e.tag, "addr", out_addr, e.a);
                check64(e.tag, "vmid", 64'(out_vmid), 64'(e.v));
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [63:0] A = 64'h1122_3344_5566_7788;
    localparam logic [63:0] B = 64'hF0E1_D2C3_B4A5_9687;

    initial begin
        for (int q = 0; q < NQ; q++) begin
            m_den[q] = 0; m_pen[q] = 0; m_cen[q] = 0; m_qen[q] = 0; m_ten[q] = 0;
            m_cnt[q] = 0; m_rep[q] = 0; m_dv[q] = 0; m_dm[q] = 0;
            m_pv[q] = 0; m_cv[q] = 0; m_qv[q] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        check64("R1", "out_valid", 64'(out_valid), 64'd0);
        check64("R1", "out_addr", out_addr, 64'd0);
        check64("R1", "out_vmid", 64'(out_vmid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: cleared configuration passes through with VMID zero
        send_lit(0, 2'd0, A, A, 16'h0, "R1");
        send_lit(0, 2'd1, B, B, 16'h0, "R1");

        // R3 / R6: data override, count 0
        cfg_write(0, 1, 32'hAABB_CCDD);
        cfg_write(0, 2, {16'hFF00, 16'h1234});
        cfg_write(0, 0, ctrl(1, 0, 0, 0, 0, 0));
        send_lit(0, 2'd0, A, A, 16'h1134, "R3");
        send(0, 2'd0, B, "R6");

        // R4: worked example N=8, then other boundaries
        cfg_write(0, 0, ctrl(1, 0, 0, 0, 0, 8));
        send_lit(0, 2'd0, A, 64'hAA22_3344_5566_7788, 16'h1134, "R4");
        cfg_write(0, 0, ctrl(1, 0, 0, 0, 0, 32));
        send_lit(0, 2'd0, A, 64'hAABB_CCDD_5566_7788, 16'h1134, "R4");
        cfg_write(0, 0, ctrl(1, 0, 0, 0, 0, 1));
        send(0, 2'd0, A, "R4");
        send(0, 2'd0, B, "R4");
        cfg_write(0, 0, ctrl(1, 0, 0, 0, 0, 31));
        send(0, 2'd0, A, "R4");
        send(0, 2'd0, B, "R4");
        cfg_write(0, 0, ctrl(1, 0, 0, 0, 0, 16));
        send(0, 2'd0, B, "R4");

        // R5: clamped counts
        cfg_write(0, 0, ctrl(1, 0, 0, 0, 0, 40));
        send_lit(0, 2'd0, A, 64'hAABB_CCDD_5566_7788, 16'h1134, "R5");
        cfg_write(0, 0, ctrl(1, 0, 0, 0, 0, 63));
        send_lit(0, 2'd0, B, 64'hAABB_CCDD_B4A5_9687, 16'hF034, "R5");

        // R6: other masks
        cfg_write(0, 2, {16'h0F0F, 16'hABCD});
        send(0, 2'd0, A, "R6");
        cfg_write(0, 2, {16'hFFFF, 16'h0000});
        send_lit(0, 2'd0, B, 64'hAABB_CCDD_B4A5_9687, 16'hF0E1, "R6");

        // R7 / R8: prefetch and completion
        cfg_write(0, 3, {16'h0C0C, 16'h0A0A});
        cfg_write(0, 0, ctrl(1, 1, 1, 0, 0, 32));
        send_lit(0, 2'd1, A, A, 16'h0A0A, "R7");
        send_lit(0, 2'd2, B, B, 16'h0C0C, "R8");

        // R9: fallback order with prefetch override off
        cfg_write(0, 4, 32'h0000_7777);
        cfg_write(0, 0, ctrl(1, 0, 1, 0, 0, 32));
        send_lit(0, 2'd1, A, A, 16'h0000, "R9");
        cfg_write(0, 0, ctrl(1, 0, 1, 0, 1, 32));
        send_lit(0, 2'd1, A, A, 16'h1122, "R9");
        cfg_write(0, 0, ctrl(1, 0, 1, 1, 0, 32));
        send_lit(0, 2'd1, B, B, 16'h7777, "R9");
        cfg_write(0, 0, ctrl(1, 0, 1, 1, 1, 32));
        send_lit(0, 2'd1, B, B, 16'h7777, "R9");
        send_lit(0, 2'd2, B, B, 16'h0C0C, "R8");

        // R12: reserved kind with data override on
        send_lit(0, 2'd3, A, A, 16'h7777, "R12");

        // R10: other queues untouched, then a write to queue 2 only
        send_lit(1, 2'd0, A, A, 16'h0, "R10");
        cfg_write(2, 0, ctrl(1, 0, 0, 0, 0, 4));
        cfg_write(2, 1, 32'h9000_0000);
        send_lit(2, 2'd0, A, 64'h9122_3344_5566_7788, 16'h0, "R10");
        send_lit(1, 2'd0, A, A, 16'h0, "R10");
        send_lit(3, 2'd2, B, B, 16'h0, "R10");
        send(0, 2'd0, A, "R10");

        // R11: selects 5..7 ignored
        cfg_write(0, 5, 32'hFFFF_FFFF);
        cfg_write(0, 6, 32'h0000_0000);
        cfg_write(0, 7, 32'h1234_5678);
        send(0, 2'd0, B, "R11");
        send(0, 2'd1, A, "R11");

        // R2: back to back then idle hold
        send(0, 2'd0, A, "R2");
        send(2, 2'd0, B, "R2");
        send(1, 2'd2, A, "R2");
        @(negedge clk);
        check64("R2", "idle valid", 64'(out_valid), 64'd0);
        check64("R2", "idle addr", out_addr, last_addr);
        check64("R2", "idle vmid", 64'(out_vmid), 64'(last_vmid));

        repeat (2) @(negedge clk);
        check64("R2", "pending results", 64'(sbq.size()), 64'd0);
        finish_run();
    end
endmodule